// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the control and status register of a flash self-programming unit, together with the logic that sequences it. Software arms a command by writing the register with the enable bit set. The command runs only if a store-program strobe from the CPU arrives within a short window after that write. A command that does not run in time disarms itself. Erase, write and lock commands then hold the enable bit until the flash model reports completion.

The block drives a one-cycle pulse for each executed command: page erase, page write, buffer load, lock programming and section re-enable. It also pulses when a buffer load is aborted. A section-busy flag marks the read-while-write section as unreadable from the start of an erase or write until software re-enables it. A load-program strobe that arrives shortly after a lock command is armed turns into a lock-bit or fuse-bit read select. A ready interrupt is raised while the block is idle and interrupts are enabled.

Top module: `spm_cmd_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and every pulse, select, busy and interrupt output is low.
- R2: Register bit 5 always reads 0. Writes to bit 6 (section busy) are ignored. Bit 7 is a plain read/write interrupt enable.
- R3: When the controller is not running, a write with bit 0 set arms exactly one command. The priority is lock (bit 3), then page write (bit 2), then page erase (bit 1), then re-enable (bit 4), then buffer load (bit 0 alone). While armed, the register reads back bit 0 plus that command's bit only. A write with bit 0 clear disarms.
- R4: Call the write edge T. A store strobe sampled at edges T+1 to T+4 executes the armed command. The matching pulse output is high for the one cycle after the executing edge.
- R5: If no store strobe arrives by edge T+4, the command and bit 0 clear at edge T+4. A store strobe after that has no effect.
- R6: An executed erase or write sets the section-busy flag (register bit 6 and `sect_busy`). Bit 0 and the command bit stay set until a `flash_done` pulse, and then clear.
- R7: An executed lock command pulses `lock_o` and latches `lock_data_i` onto `lock_bits_o`. It leaves the section-busy flag unchanged. It holds bits 3 and 0 until `flash_done`.
- R8: A load strobe sampled at edges T+1 to T+3 while lock is armed pulses `rd_lock_o` if `load_addr0` is 0, or `rd_fuse_o` if it is 1. At edge T+4 neither pulses.
- R9: An executed re-enable or buffer load clears the section-busy flag.
- R10: While an erase, write or lock is running, register writes change only bit 7. A re-enable is refused in this state.
- R11: Writing bit 4 while a buffer load is armed pulses `abort_o` and disarms the load. A later store strobe then produces no `fill_o`.
- R12: `irq` equals bit 7 AND `gie` AND NOT bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| store_stb | input | 1 | Store-program instruction strobe |
| load_stb | input | 1 | Load-program instruction strobe |
| load_addr0 | input | 1 | Address bit 0 of the load: 0 selects lock bits, 1 selects fuse bits |
| gie | input | 1 | Global interrupt enable |
| flash_done | input | 1 | Flash completion pulse |
| lock_data_i | input | 8 | Lock-bit value for the lock command |
| erase_o | output | 1 | Page erase pulse |
| write_o | output | 1 | Page write pulse |
| fill_o | output | 1 | Buffer load pulse |
| lock_o | output | 1 | Lock programming pulse |
| reen_o | output | 1 | Section re-enable pulse |
| abort_o | output | 1 | Buffer load abort pulse |
| lock_bits_o | output | 8 | Lock value latched at lock execution |
| rd_lock_o | output | 1 | Lock-bit read select pulse |
| rd_fuse_o | output | 1 | Fuse-bit read select pulse |
| sect_busy | output | 1 | Section busy flag |
| irq | output | 1 | Ready interrupt request |

## Verification
A wrong armed-command state shows in the register readback in the cycle after the write. If the state is not caught there, it shows one cycle after the executing store strobe, as the wrong pulse or as no pulse. A window counter that is off by one shows only at the boundary delays. For that reason, the store and load strobes are swept over every delay on both sides of the window edge. A stale section-busy flag or a stale running state persists until the next re-enable or completion. Each is read back right after the event that should have changed it.

// File: rtl/spm_ctrl_pkg.sv
package spm_ctrl_pkg;
  typedef enum logic [2:0] {
    C_NONE, C_FILL, C_ERASE, C_WRITE, C_LOCK, C_REEN
  } cmd_e;

  localparam int B_GO   = 0;
  localparam int B_ERS  = 1;
  localparam int B_WR   = 2;
  localparam int B_LOCK = 3;
  localparam int B_REEN = 4;
  localparam int B_IE   = 7;
  localparam logic [7:0] WR_MASK = 8'h9F;

  // Pick the single command a write arms, highest priority first.
  function automatic cmd_e pick_cmd(logic [7:0] w);
    if (!w[B_GO])       return C_NONE;
    else if (w[B_LOCK]) return C_LOCK;
    else if (w[B_WR])   return C_WRITE;
    else if (w[B_ERS])  return C_ERASE;
    else if (w[B_REEN]) return C_REEN;
    else                return C_FILL;
  endfunction

  // Readback bits [4:0] for a command held in the register.
  function automatic logic [4:0] cmd_bits(cmd_e c);
    case (c)
      C_FILL:  return 5'b00001;
      C_ERASE: return 5'b00011;
      C_WRITE: return 5'b00101;
      C_LOCK:  return 5'b01001;
      C_REEN:  return 5'b10001;
      default: return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/cmd_window.sv
module cmd_window #(
  parameter int WIN  = 4,
  parameter int LOOK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  output logic expire,
  output logic look_ok
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt <= '0;
    else if (restart)                       cnt <= '0;
    else if (active && cnt != CW'(WIN - 1)) cnt <= cnt + 1'b1;
  end

  assign expire  = active && (cnt == CW'(WIN - 1));
  assign look_ok = active && (cnt < CW'(LOOK));

  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < CW'(WIN)));
endmodule

// File: rtl/sect_flag.sv
module sect_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic busy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_o <= 1'b0;
    else if (set_i) busy_o <= 1'b1;
    else if (clr_i) busy_o <= 1'b0;
  end

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !busy_o);
endmodule

// File: rtl/cfg_rd_sel.sv
module cfg_rd_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic addr0_i,
  output logic rd_lock_o,
  output logic rd_fuse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lock_o <= 1'b0;
      rd_fuse_o <= 1'b0;
    end else begin
      rd_lock_o <= req_i && !addr0_i;
      rd_fuse_o <= req_i && addr0_i;
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_lock_o && rd_fuse_o));
endmodule

// File: rtl/spm_cmd_ctrl.sv
module spm_cmd_ctrl
  import spm_ctrl_pkg::*;
#(
  parameter int WIN_CYC  = 4,
  parameter int LOOK_CYC = 3,
  parameter int LOCK_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              store_stb,
  input  logic              load_stb,
  input  logic              load_addr0,
  input  logic              gie,
  input  logic              flash_done,
  input  logic [LOCK_W-1:0] lock_data_i,
  output logic              erase_o,
  output logic              write_o,
  output logic              fill_o,
  output logic              lock_o,
  output logic              reen_o,
  output logic              abort_o,
  output logic [LOCK_W-1:0] lock_bits_o,
  output logic              rd_lock_o,
  output logic              rd_fuse_o,
  output logic              sect_busy,
  output logic              irq
);
  cmd_e cmd;
  logic running, irq_en;
  logic [7:0] wkeep;
  cmd_e wr_cmd;
  logic armed, go_bit;
  logic ev_abort, ev_arm, ev_exec, ev_expire, ev_done;
  logic win_expire, win_look;
  logic exec_long, sect_set, sect_clr, look_req;

  assign wkeep     = csr_wdata & WR_MASK;
  assign wr_cmd    = pick_cmd(wkeep);
  assign go_bit    = (cmd != C_NONE);
  assign armed     = go_bit && !running;
  assign ev_abort  = armed && (cmd == C_FILL) && csr_we && wkeep[B_REEN];
  assign ev_arm    = csr_we && !running && !ev_abort && (wr_cmd != C_NONE);
  assign ev_exec   = armed && !csr_we && store_stb;
  assign ev_expire = armed && !csr_we && !store_stb && win_expire;
  assign ev_done   = running && flash_done;
  assign exec_long = (cmd == C_ERASE) || (cmd == C_WRITE) || (cmd == C_LOCK);
  assign sect_set  = ev_exec && ((cmd == C_ERASE) || (cmd == C_WRITE));
  assign sect_clr  = ev_exec && ((cmd == C_REEN) || (cmd == C_FILL));
  assign look_req  = (cmd == C_LOCK) && win_look && load_stb;

  cmd_window #(.WIN(WIN_CYC), .LOOK(LOOK_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(ev_arm), .active(armed),
    .expire(win_expire), .look_ok(win_look)
  );

  sect_flag u_sect (
    .clk(clk), .rst_n(rst_n), .set_i(sect_set), .clr_i(sect_clr),
    .busy_o(sect_busy)
  );

  cfg_rd_sel u_rdsel (
    .clk(clk), .rst_n(rst_n), .req_i(look_req), .addr0_i(load_addr0),
    .rd_lock_o(rd_lock_o), .rd_fuse_o(rd_fuse_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= C_NONE;
      running <= 1'b0;
      irq_en  <= 1'b0;
    end else begin
      if (csr_we) irq_en <= wkeep[B_IE];
      if (ev_done) begin
        cmd     <= C_NONE;
        running <= 1'b0;
      end else if (csr_we && !running) begin
        cmd <= ev_abort ? C_NONE : wr_cmd;
      end else if (ev_exec) begin
        if (exec_long) running <= 1'b1;
        else           cmd     <= C_NONE;
      end else if (ev_expire) begin
        cmd <= C_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_o     <= 1'b0;
      write_o     <= 1'b0;
      fill_o      <= 1'b0;
      lock_o      <= 1'b0;
      reen_o      <= 1'b0;
      abort_o     <= 1'b0;
      lock_bits_o <= '0;
    end else begin
      erase_o <= ev_exec && (cmd == C_ERASE);
      write_o <= ev_exec && (cmd == C_WRITE);
      fill_o  <= ev_exec && (cmd == C_FILL);
      lock_o  <= ev_exec && (cmd == C_LOCK);
      reen_o  <= ev_exec && (cmd == C_REEN);
      abort_o <= ev_abort;
      if (ev_exec && (cmd == C_LOCK)) lock_bits_o <= lock_data_i;
    end
  end

  assign csr_rdata = {irq_en, sect_busy, 1'b0, cmd_bits(cmd)};
  assign irq       = irq_en && gie && !go_bit;

  a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_o, write_o, fill_o, lock_o, reen_o, abort_o}));
  a_r6_busy_on_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || write_o) |-> sect_busy);
  a_r9_free_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o || reen_o) |-> !sect_busy);
  a_r10_hold_running: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !flash_done) |=> (cmd == $past(cmd)));
  a_r12_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (csr_rdata[B_GO] == 1'b0));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[5] == 1'b0);
endmodule

// File: tb/test_spm_cmd_ctrl.sv
module test_spm_cmd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0, store_stb = 1'b0, load_stb = 1'b0, load_addr0 = 1'b0;
  logic gie = 1'b0, flash_done = 1'b0;
  logic [7:0] csr_wdata = 8'h00, lock_data_i = 8'h00;
  logic [7:0] csr_rdata, lock_bits_o;
  logic erase_o, write_o, fill_o, lock_o, reen_o, abort_o;
  logic rd_lock_o, rd_fuse_o, sect_busy, irq;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  spm_cmd_ctrl i_spm_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .store_stb(store_stb), .load_stb(load_stb),
    .load_addr0(load_addr0), .gie(gie), .flash_done(flash_done),
    .lock_data_i(lock_data_i), .erase_o(erase_o), .write_o(write_o),
    .fill_o(fill_o), .lock_o(lock_o), .reen_o(reen_o), .abort_o(abort_o),
    .lock_bits_o(lock_bits_o), .rd_lock_o(rd_lock_o), .rd_fuse_o(rd_fuse_o),
    .sect_busy(sect_busy), .irq(irq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    csr_we = 1'b1; csr_wdata = v;
    tick();
    csr_we = 1'b0;
  endtask

  task automatic store();
    store_stb = 1'b1;
    tick();
    store_stb = 1'b0;
  endtask

  task automatic finish_flash();
    flash_done = 1'b1;
    tick();
    flash_done = 1'b0;
  endtask

  function automatic logic [5:0] pulses();
    return {erase_o, write_o, fill_o, lock_o, reen_o, abort_o};
  endfunction

  // Expected armed readback from the priority rule.
  function automatic logic [7:0] exp_arm(logic [3:0] c);
    if (c[2])      return 8'h09;
    else if (c[1]) return 8'h05;
    else if (c[0]) return 8'h03;
    else if (c[3]) return 8'h11;
    else           return 8'h01;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 rdata", csr_rdata, 8'h00);
    check("R1 outputs", {pulses(), rd_lock_o, rd_fuse_o, sect_busy, irq}, 0);

    // R2 reserved and read-only bits
    wr(8'h60);
    check("R2 bits5/6 ignored", csr_rdata, 8'h00);
    wr(8'hE0);
    check("R2 bit7 rw", csr_rdata, 8'h80);

    // R12 interrupt
    gie = 1'b1; tick();
    check("R12 irq idle", irq, 1);
    wr(8'h81);
    check("R12 irq masked by go", irq, 0);
    wr(8'h80);
    gie = 1'b0; tick();
    check("R12 irq gie off", irq, 0);
    wr(8'h00);

    // R3 priority sweep over all command bit combinations
    for (int c = 0; c < 16; c++) begin
      wr({3'b000, c[3], c[2:0], 1'b1});
      check($sformatf("R3 arm c=%0d", c), csr_rdata, exp_arm(c[3:0]));
      wr(8'h00);
      check($sformatf("R3 disarm c=%0d", c), csr_rdata, 8'h00);
    end

    // R4/R5 store-delay sweep on a page erase (then R6 completion)
    for (int k = 0; k < 6; k++) begin
      wr(8'h03);
      for (int j = 0; j < k; j++) tick();
      if (k == 4) check("R5 expired", csr_rdata, 8'h00);
      store();
      check($sformatf("R4 erase pulse k=%0d", k), erase_o, (k < 4) ? 1 : 0);
      if (k < 4) begin
        check("R6 running readback", csr_rdata, 8'h43);
        check("R6 sect_busy", sect_busy, 1);
        tick();
        check("R4 single pulse", pulses(), 0);
        // R10 re-enable refused while running
        wr(8'h11);
        check("R10 write ignored", csr_rdata, 8'h43);
        finish_flash();
        check("R6 done clears", csr_rdata, 8'h40);
        wr(8'h11); store();
        check("R9 reen pulse", reen_o, 1);
        check("R9 reen clears busy", csr_rdata, 8'h00);
      end else begin
        check("R5 late store no effect", {pulses(), sect_busy}, 0);
      end
    end

    // R6 page write, R2 bit6 write ignored while set, R9 fill clears busy
    wr(8'h05); store();
    check("R6 write pulse", write_o, 1);
    finish_flash();
    wr(8'h00);
    check("R2 busy write ignored", csr_rdata, 8'h40);
    wr(8'h01); store();
    check("R9 fill pulse", fill_o, 1);
    check("R9 fill clears busy", {sect_busy, csr_rdata}, 9'h000);

    // R7 lock programming
    lock_data_i = 8'hA5;
    wr(8'h09); store();
    lock_data_i = 8'h00;
    check("R7 lock pulse", lock_o, 1);
    check("R7 lock data", lock_bits_o, 8'hA5);
    check("R7 holds", csr_rdata, 8'h09);
    finish_flash();
    check("R7 done", csr_rdata, 8'h00);

    // R8 lock/fuse read select sweep
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 2; a++) begin
        wr(8'h09);
        for (int j = 0; j < k; j++) tick();
        load_stb = 1'b1; load_addr0 = a[0];
        tick();
        load_stb = 1'b0; load_addr0 = 1'b0;
        check($sformatf("R8 sel k=%0d a=%0d", k, a), {rd_lock_o, rd_fuse_o},
              (k < 3) ? ((a == 0) ? 2 : 1) : 0);
        wr(8'h00);
      end
    end

    // R11 abort of an armed buffer load
    wr(8'h01);
    wr(8'h11);
    check("R11 abort pulse", abort_o, 1);
    check("R11 disarmed", csr_rdata, 8'h00);
    store();
    check("R11 no fill", fill_o, 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule